// File: doc/BRIEF.md
# Synchronous Byte-Write Memory Datapath

This block is a single-port synchronous memory with a small internal array of words, each split into 9-bit byte lanes (8 data bits plus a parity bit that is stored and returned as-is). Every control and address input is sampled on the rising clock edge. A command cycle is one of three kinds: deselect (chip enable inactive), write (chip enable active with either write enable low), or read (chip enable active with both write enables high). A global write enable stores every lane of the addressed word. A separate byte-write enable stores only the lanes whose individual select is low.

Read data leaves through an output stage whose latency is chosen by a static mode input. In flow-through mode (mode low), the array is read from the registered address and the result goes straight to the data pins in the cycle after the command edge. In pipeline mode (mode high), the same data passes through one more rising-edge register and appears one cycle later. An asynchronous active-low output enable gates the drivers. Driving it high turns them off at once. Driving it low turns them on only while a read result is being presented. A read issued with the output enable high (a dummy read) runs internally like any other read, so the bus can turn from read to write without a deselect cycle.

The tristate pins are modelled as a data vector plus a drive-enable flag. The data vector reads zero whenever the drivers are off. The memory accepts a command on every clock and applies no back-pressure, so the interface carries no valid/ready pair: every sampled cycle is a command.

Top module: `sbw_core`

## Requirements
- R1: While reset is held and after it is released with no command issued, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: A selected cycle with `gwe_n` low writes `wdata` into all lanes of the word at `addr`, whatever `bwe_n` and `lane_n` are.
- R3: A selected cycle with `gwe_n` high and `bwe_n` low writes lane i (bits 9*i+8 down to 9*i of the word) only when `lane_n[i]` is low. The other lanes keep their contents.
- R4: A selected cycle with `gwe_n` and `bwe_n` both high is a read and changes no stored lane, even with every `lane_n` bit low.
- R5: With `pipe_mode` low, a read sampled at edge k presents the word on `dq_out` with `dq_oe` high in the cycle that follows edge k.
- R6: With `pipe_mode` high, a read sampled at edge k presents the word in the cycle that follows edge k+1, one cycle later than R5.
- R7: `dq_oe` is 0 whenever `oe_n` is high, and it changes within the same cycle as `oe_n`. A read made while `oe_n` is high still completes internally, and a write may follow it directly.
- R8: The result slot of a write cycle never drives: `dq_oe` is 0 in that slot.
- R9: A deselect sampled at an edge leaves the drivers off in its result slot (single-cycle deselect).
- R10: A read of an address on the cycle right after a write to it returns the newly written lanes, in both modes.
- R11: The ninth bit of every lane is stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control and output registers |
| pipe_mode | input | 1 | Static latency select: 1 pipeline, 0 flow-through |
| ce_n | input | 1 | Active-low chip enable; high is a deselect cycle |
| gwe_n | input | 1 | Active-low global write, all lanes |
| bwe_n | input | 1 | Active-low byte-write enable |
| lane_n | input | LANES | Active-low per-lane selects for byte write |
| addr | input | ADDR_W | Word address for the command |
| wdata | input | LANES*9 | Write data, captured on the command edge |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | LANES*9 | Read data; zero while not driving |
| dq_oe | output | 1 | High while the data drivers are on |

## Verification
The assertions assume that `pipe_mode` changes only after at least two deselect cycles, so that no read or write result slot straddles a mode change. They also take `oe_n` to be stable at each rising edge. The stimulus drives every input, `oe_n` included, just after the falling edge. The one exception is the asynchronous output-enable test, which toggles `oe_n` in the middle of a low phase and restores it before the next rising edge. Mode is switched only inside a run of three deselect cycles.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned SBW_LANE_BITS = 9;

  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } sbw_mode_e;
endpackage

// File: rtl/sbw_cmd_decode.sv
module sbw_cmd_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             ce_n,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  output logic             rd_cmd,
  output logic [LANES-1:0] lane_we
);
  // Global write overrides the per-lane selects; byte write honours them.
  always_comb begin
    lane_we = '0;
    rd_cmd  = 1'b0;
    if (!ce_n) begin
      if (!gwe_n)      lane_we = '1;
      else if (!bwe_n) lane_we = ~lane_n;
      else             rd_cmd  = 1'b1;
    end
  end
endmodule

// File: rtl/sbw_array.sv
module sbw_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/sbw_out_stage.sv
module sbw_out_stage
  import sbw_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              sel_valid;
  logic [DATA_W-1:0] sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else begin
      hold_valid <= src_valid;
      hold_data  <= src_data;
    end
  end

  always_comb begin
    if (sbw_mode_e'(pipe_mode) == MODE_PIPE) begin
      sel_valid = hold_valid;
      sel_data  = hold_data;
    end else begin
      sel_valid = src_valid;
      sel_data  = src_data;
    end
    dq_oe  = sel_valid & ~oe_n;
    dq_out = dq_oe ? sel_data : '0;
  end
endmodule

// File: rtl/sbw_core.sv
module sbw_core
  import sbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = LANES * SBW_LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              ce_n,
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              rd_cmd;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] arr_rdata;

  sbw_cmd_decode #(.LANES(LANES)) u_dec (
    .ce_n    (ce_n),
    .gwe_n   (gwe_n),
    .bwe_n   (bwe_n),
    .lane_n  (lane_n),
    .rd_cmd  (rd_cmd),
    .lane_we (lane_we)
  );

  // Read address and read flag are captured on the command edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_cmd;
      if (rd_cmd) rd_addr_q <= addr;
    end
  end

  sbw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(SBW_LANE_BITS)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (addr),
    .wdata   (wdata),
    .raddr   (rd_addr_q),
    .rdata   (arr_rdata)
  );

  sbw_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .src_valid (rd_valid_q),
    .src_data  (arr_rdata),
    .oe_n      (oe_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker (
  input logic clk,
  input logic rst_n,
  input logic pipe_mode,
  input logic ce_n,
  input logic gwe_n,
  input logic bwe_n,
  input logic oe_n,
  input logic dq_oe
);
  logic rd_seen, wr_seen;
  assign rd_seen = !ce_n && gwe_n && bwe_n;
  assign wr_seen = !ce_n && (!gwe_n || !bwe_n);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  p_flow_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_seen) |=> (dq_oe || oe_n));

  p_pipe_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_seen) |=> ##1 (dq_oe || oe_n));

  p_flow_wr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && wr_seen) |=> !dq_oe);

  p_pipe_wr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && wr_seen) |=> ##1 !dq_oe);

  p_flow_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && ce_n) |=> !dq_oe);

  p_pipe_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && ce_n) |=> ##1 !dq_oe);
endmodule

bind sbw_core sbw_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_mode (pipe_mode),
  .ce_n      (ce_n),
  .gwe_n     (gwe_n),
  .bwe_n     (bwe_n),
  .oe_n      (oe_n),
  .dq_oe     (dq_oe)
);

// File: tb/sim_sbw_core.sv
`timescale 1ns/1ps
module sim_sbw_core;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0, rst_n = 1'b0, pipe_mode = 1'b0;
  logic ce_n = 1'b1, gwe_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [LN-1:0] lane_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #4 clk = ~clk;

  sbw_core #(.ADDR_W(AW), .LANES(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce_n(ce_n), .gwe_n(gwe_n),
    .bwe_n(bwe_n), .lane_n(lane_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [1 << AW];

  typedef struct {
    int            due;
    bit            rd;
    logic [DW-1:0] data;
    string         tag;
  } item_t;
  item_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one command per cycle, expected slot pushed to the scoreboard.
  task automatic op(input bit sel, input bit g_n, input bit b_n, input logic [LN-1:0] ln,
                    input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    ce_n = !sel; gwe_n = g_n; bwe_n = b_n; lane_n = ln; addr = a; wdata = d;
    it.due = cyc + (pipe_mode ? 2 : 1);
    it.rd  = sel && g_n && b_n;
    it.tag = tag;
    if (sel && !g_n) model[a] = d;
    else if (sel && !b_n)
      for (int i = 0; i < LN; i++)
        if (!ln[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
    it.data = it.rd ? model[a] : '0;
    sb.push_back(it);
  endtask

  task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] ln, input string tag);
    op(1'b1, 1'b0, 1'b1, ln, a, d, tag);
  endtask
  task automatic wr_lanes(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] ln, input string tag);
    op(1'b1, 1'b1, 1'b0, ln, a, d, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    op(1'b1, 1'b1, 1'b1, '1, a, {DW{1'b1}}, tag);
  endtask
  task automatic idle(input string tag);
    op(1'b0, 1'b0, 1'b0, '0, '0, '0, tag);
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] v;
    v = {$urandom, $urandom};
    return v;
  endfunction

  // Monitor: compares each due slot against the current output enable.
  always @(negedge clk) begin
    #2;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      bit exp_oe;
      logic [DW-1:0] exp_d;
      it = sb.pop_front();
      exp_oe = it.rd && !oe_n;
      exp_d  = exp_oe ? it.data : '0;
      checks++;
      if (dq_oe !== exp_oe || dq_out !== exp_d) begin
        errors++;
        $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
                 it.tag, dq_oe, dq_out, exp_oe, exp_d);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] par;
    repeat (3) @(negedge clk);
    #1;
    check(dq_oe === 1'b0, "R1 oe in reset", {{(DW-1){1'b0}}, dq_oe}, '0);
    check(dq_out === '0, "R1 data in reset", dq_out, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(dq_oe === 1'b0 && dq_out === '0, "R1 after release", dq_out, '0);

    // Flow-through phase
    for (int a = 0; a < 8; a++) wr_all(AW'(a), rnd(), LN'(a), "R2 global write");
    for (int a = 0; a < 8; a++) rd(AW'(a), "R5 flow read / R2");
    wr_lanes(8'd3, rnd(), 4'b1010, "R3 lanes 0,2");
    wr_lanes(8'd4, rnd(), 4'b0111, "R3 lane 3");
    wr_lanes(8'd5, rnd(), 4'b1111, "R3 no lane");
    rd(8'd3, "R3 readback");
    rd(8'd4, "R3 readback");
    rd(8'd5, "R3 readback");
    op(1'b1, 1'b1, 1'b1, 4'b0000, 8'd6, rnd(), "R4 read with lanes low");
    rd(8'd6, "R4 unchanged");
    par = '0;
    for (int i = 0; i < LN; i++) par[i*LW +: LW] = 9'h100 | 9'(i * 17);
    wr_all(8'd9, par, 4'b1111, "R11 parity bits");
    rd(8'd9, "R11 parity readback");
    wr_all(8'd10, rnd(), 4'b0000, "R10 write");
    rd(8'd10, "R10 flow read after write");
    wr_lanes(8'd10, rnd(), 4'b1100, "R10 partial write");
    rd(8'd10, "R10 flow read after partial");
    rd(8'd1, "R9 read before deselect");
    idle("R9 flow deselect");
    rd(8'd2, "R9 read after deselect");
    idle("R9 flow deselect");
    rd(8'd1, "R8 read");
    wr_all(8'd11, rnd(), 4'b0000, "R8 flow write slot");
    rd(8'd11, "R8 read after write");

    // Asynchronous output enable during a flow read slot
    rd(8'd7, "R7 async read");
    idle("R7 async slot");
    #1 oe_n = 1'b1;
    #0.5;
    check(dq_oe === 1'b0, "R7 oe high turns drivers off", {{(DW-1){1'b0}}, dq_oe}, '0);
    #1.5 oe_n = 1'b0;
    #0.5;
    check(dq_oe === 1'b1 && dq_out === model[7], "R7 oe low restores read data", dq_out, model[7]);
    idle("R7 deselect");

    // Switch to pipeline during deselects
    idle("R9 gap");
    idle("R9 gap");
    pipe_mode = 1'b1;
    idle("R9 pipe gap");
    idle("R9 pipe gap");
    for (int a = 0; a < 4; a++) rd(AW'(a), "R6 pipeline read");
    wr_all(8'd20, rnd(), 4'b0101, "R8 pipe write slot");
    rd(8'd20, "R10 pipe read after write");
    wr_lanes(8'd20, rnd(), 4'b0011, "R3 pipe lanes 2,3");
    rd(8'd20, "R10 pipe read after partial");
    rd(8'd9, "R11 pipe parity");
    idle("R9 pipe deselect");
    rd(8'd3, "R9 pipe read after deselect");
    idle("R9 pipe deselect");
    idle("R9 pipe deselect");

    // Dummy reads, then a write without deselect
    oe_n = 1'b1;
    rd(8'd2, "R7 dummy read");
    rd(8'd3, "R7 dummy read");
    wr_all(8'd2, rnd(), 4'b1111, "R7 write after dummy");
    rd(8'd2, "R7 read after dummy/write");
    oe_n = 1'b0;
    rd(8'd3, "R7 read after dummy");
    for (int k = 0; k < 4; k++) idle("drain");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule